// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block is the interrupt control register of a small 8-bit microcontroller core. It latches three event sources: a timer rollover pulse, a rising edge on an external interrupt pin, and a change on any of six port pins. Each source has its own sticky flag and its own enable bit. A peripheral-group enable passes a separate set of peripheral requests. A global enable gates the single request that goes to the CPU. The CPU reads and writes all eight register bits over a simple bus. It clears a flag by writing 0 to it.

The change detector compares the synchronized port pins with a stored copy of their previous values. Only pins whose bit is set in a separate per-pin change-mask register take part. Reading the port reloads the stored copy. A power-on reset loads the stored copy once the synchronizers have settled, so start-up raises no false change. A soft reset (master clear or watchdog) clears the control register but keeps the stored copy and the change mask. A change that has not been serviced therefore flags again straight after a soft reset.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After power-on reset, all eight control bits read 0, the change mask reads 0 and the request output is low.
- R2: The control register is read and written as one byte with bit 7 = global enable, bit 6 = peripheral enable, bit 5 = timer enable, bit 4 = external-pin enable, bit 3 = change enable, bit 2 = timer flag, bit 1 = external-pin flag, bit 0 = change flag. A written value reads back unchanged when no event is pending.
- R3: Each flag sets on its event whatever the state of its own enable, the peripheral enable and the global enable.
- R4: A flag stays set until a bus write puts 0 in that bit or a reset occurs. Hardware never clears it.
- R5: A one-cycle pulse on the timer rollover input sets the timer flag at the next clock edge.
- R6: The external-pin flag sets on a rising edge of the pin after a two-flop synchronizer. A steady high level or a falling edge does not set it.
- R7: The change flag sets when an enabled port pin, after a two-flop synchronizer, differs from its stored previous value. Pins whose mask bit is 0 are ignored. A port read strobe reloads the stored values from the synchronized pins, and it also drives port_rdata.
- R8: A soft reset clears all eight control bits at the next edge. It keeps the stored previous values and the change mask, so a mismatch that remains sets the change flag again one cycle later.
- R9: irq = global enable AND ((timer flag AND timer enable) OR (ext flag AND ext enable) OR (change flag AND change enable) OR (peripheral enable AND any peripheral request)).
- R10: When a hardware set and a bus write of 0 to the same flag occur in the same cycle, the flag ends up set.
- R11: Port pins that are already high during power-on reset do not raise the change flag once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous soft reset that keeps the stored previous values and the change mask |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Current control register value |
| mask_wr | input | 1 | Write strobe for the change mask |
| mask_wdata | input | PORT_W | Write data for the change mask |
| mask_rdata | output | PORT_W | Current change mask |
| port_rd | input | 1 | Port read strobe; reloads the stored previous values |
| port_rdata | output | PORT_W | Synchronized port pin values |
| tmr_wrap | input | 1 | One-cycle timer rollover pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | PORT_W | Asynchronous port pins |
| periph_req | input | PER_W | Peripheral-group interrupt requests |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions check on every cycle that the request stays low while the global enable is 0 and that a set flag holds until a write or a soft reset. They also check that a rollover pulse always leaves the timer flag set, that a soft reset leaves the register at zero, and that a soft reset leaves the stored previous values unchanged. Only the bench scenarios can show the full request equation over every register value and the edge-versus-level behaviour of the external pin. The same holds for the masking of each port pin, the reassertion after a soft reset and the absence of a false change after power-on.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned CTL_W = 8;

    typedef struct packed {
        logic gie;
        logic peie;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_f;
        logic ext_f;
        logic chg_f;
    } ctl_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/port_mismatch.sv
module port_mismatch #(
    parameter int unsigned W      = 6,
    parameter int unsigned SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] pins_s,
    input  logic         port_rd,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] mask_q,
    output logic         chg_evt
);
    localparam int unsigned TRK_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [W-1:0]     prev;
        logic [W-1:0]     mask;
        logic [TRK_W-1:0] trk;
    } pm_state_t;

    pm_state_t st_d, st_q;
    logic      tracking;

    always_comb begin
        st_d     = st_q;
        tracking = (st_q.trk != '0);
        chg_evt  = !tracking && (|((pins_s ^ st_q.prev) & st_q.mask));
        if (tracking) st_d.trk = st_q.trk - 1'b1;
        if (tracking || port_rd) st_d.prev = pins_s;
        if (mask_wr) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.mask <= '0;
            st_q.trk  <= TRK_W'(SETTLE);
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

    // R8: a soft reset alone does not disturb the stored previous values
    a_r8_prev_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !port_rd && !tracking) |=> $stable(st_q.prev));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PORT_W      = 6,
    parameter int unsigned PER_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [CTL_W-1:0]  reg_wdata,
    output logic [CTL_W-1:0]  reg_rdata,
    input  logic              mask_wr,
    input  logic [PORT_W-1:0] mask_wdata,
    output logic [PORT_W-1:0] mask_rdata,
    input  logic              port_rd,
    output logic [PORT_W-1:0] port_rdata,
    input  logic              tmr_wrap,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PER_W-1:0]  periph_req,
    output logic              irq
);
    localparam int unsigned SETTLE = SYNC_STAGES + 1;

    typedef struct packed {
        ctl_t ctl;
        logic ext_prev;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             ext_s;
    logic [PORT_W-1:0] pins_s;
    logic             chg_evt;
    logic             ext_rise;
    logic             src_hit;

    pin_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d(port_pins), .q(pins_s)
    );

    port_mismatch #(.W(PORT_W), .SETTLE(SETTLE)) u_chg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pins_s(pins_s),
        .port_rd(port_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_q(mask_rdata), .chg_evt(chg_evt)
    );

    always_comb begin
        st_d          = st_q;
        ext_rise      = ext_s && !st_q.ext_prev;
        st_d.ext_prev = ext_s;
        if (soft_rst) begin
            st_d.ctl = '0;
        end else begin
            if (reg_wr) st_d.ctl = ctl_t'(reg_wdata);
            if (tmr_wrap) st_d.ctl.tmr_f = 1'b1;
            if (ext_rise) st_d.ctl.ext_f = 1'b1;
            if (chg_evt)  st_d.ctl.chg_f = 1'b1;
        end
        src_hit = (st_q.ctl.tmr_f && st_q.ctl.tmr_en)
               || (st_q.ctl.ext_f && st_q.ctl.ext_en)
               || (st_q.ctl.chg_f && st_q.ctl.chg_en)
               || (st_q.ctl.peie && (|periph_req));
        irq = st_q.ctl.gie && src_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.ctl;
    assign port_rdata = pins_s;

    // R9: no request while the global enable is clear
    a_r9_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[7] |-> !irq);

    // R4: a set flag persists without a write or soft reset
    a_r4_tmr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !reg_wr && !soft_rst) |=> reg_rdata[2]);
    a_r4_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && !reg_wr && !soft_rst) |=> reg_rdata[0]);

    // R5, R10: a rollover pulse always leaves the timer flag set
    a_r5_tmr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wrap && !soft_rst) |=> reg_rdata[2]);

    // R8: soft reset clears the whole register
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_rdata == '0));
endmodule

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
    localparam int unsigned PW = 6;
    localparam int unsigned QW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          mask_wr = 1'b0;
    logic [PW-1:0] mask_wdata = '0;
    logic [PW-1:0] mask_rdata;
    logic          port_rd = 1'b0;
    logic [PW-1:0] port_rdata;
    logic          tmr_wrap = 1'b0;
    logic          ext_pin = 1'b0;
    logic [PW-1:0] port_pins = '0;
    logic [QW-1:0] periph_req = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_ctrl #(.PORT_W(PW), .PER_W(QW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .port_rd(port_rd),
        .port_rdata(port_rdata), .tmr_wrap(tmr_wrap), .ext_pin(ext_pin),
        .port_pins(port_pins), .periph_req(periph_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [PW-1:0] v);
        mask_wr = 1'b1; mask_wdata = v;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic rd_port();
        port_rd = 1'b1;
        tick();
        port_rd = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic exp_irq;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 mask", mask_rdata, 0);
        chk("R1 irq", irq, 0);

        // R2 and R9: every register value, with and without peripheral requests
        for (int v = 0; v < 256; v++) begin
            periph_req = '0;
            wr_reg(v[7:0]);
            chk("R2 readback", reg_rdata, v[7:0]);
            for (int p = 0; p < 2; p++) begin
                periph_req = (p == 1) ? 4'b0100 : 4'b0000;
                #1;
                exp_irq = v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p[0]));
                chk("R9 irq", irq, exp_irq);
            end
        end
        periph_req = '0;
        wr_reg(8'h00);

        // R3, R5: timer flag while masked
        tmr_wrap = 1'b1;
        tick();
        tmr_wrap = 1'b0;
        chk("R5 R3 timer flag set while masked", reg_rdata, 8'h04);
        chk("R3 irq stays low", irq, 0);
        tick(5);
        chk("R4 timer flag sticky", reg_rdata, 8'h04);
        wr_reg(8'h00);
        chk("R4 cleared by write", reg_rdata, 8'h00);
        wr_reg(8'h04);
        reg_wr = 1'b1; reg_wdata = 8'h00; tmr_wrap = 1'b1;
        tick();
        reg_wr = 1'b0; tmr_wrap = 1'b0;
        chk("R10 set beats clear", reg_rdata, 8'h04);
        wr_reg(8'h00);

        // R6: external pin edge
        ext_pin = 1'b1;
        tick(4);
        chk("R6 rising edge sets", reg_rdata[1], 1);
        wr_reg(8'h00);
        tick(3);
        chk("R6 level does not set", reg_rdata[1], 0);
        ext_pin = 1'b0;
        tick(4);
        chk("R6 falling does not set", reg_rdata[1], 0);
        ext_pin = 1'b1;
        tick(4);
        chk("R6 second edge sets", reg_rdata[1], 1);
        wr_reg(8'h00);

        // R7: each pin alone, with the other pins masked
        for (int i = 0; i < PW; i++) begin
            port_pins = '0;
            tick(3);
            rd_port();
            wr_reg(8'h00);
            wr_mask(PW'(1) << i);
            port_pins = ~(PW'(1) << i);
            tick(4);
            chk("R7 masked pins ignored", reg_rdata[0], 0);
            port_pins = '1;
            tick(4);
            chk("R7 enabled pin sets", reg_rdata[0], 1);
            chk("R7 port value", port_rdata, 6'h3F);
            wr_reg(8'h00);
            chk("R7 mismatch resets flag", reg_rdata[0], 1);
            rd_port();
            wr_reg(8'h00);
            tick(2);
            chk("R7 reload clears mismatch", reg_rdata[0], 0);
        end

        // R8: soft reset keeps stored values
        wr_mask(6'h01);
        port_pins = 6'h3E;
        tick(4);
        wr_reg(8'hF9);
        chk("R8 pre", reg_rdata, 8'hF9);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        chk("R8 cleared", reg_rdata, 8'h00);
        chk("R8 mask kept", mask_rdata, 6'h01);
        tick();
        chk("R8 flag reasserts", reg_rdata, 8'h01);

        // R11: pins high through power-on reset
        port_pins = 6'h15;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        wr_mask(6'h3F);
        tick(6);
        chk("R11 no false change", reg_rdata[0], 0);
        port_pins = 6'h35;
        tick(4);
        chk("R11 later change detected", reg_rdata[0], 1);

        done = 1'b1;
        report();
        $finish;
    end
endmodule